// File: doc/BRIEF.md
# Command Stream Opcode Decoder

This block parses a stream of 32-bit command words that arrive one per cycle, qualified by a valid strobe. It decodes each header word by the opcode in its top four bits and produces the header's fields: register offset, class, mask, count, immediate data, lock index, extended-command kind, gather flags and restart address. It also works out how many payload words follow that header. It then counts those payload words off, tags each one as payload, and flags the final one. The word after the final payload word is taken as the next header.

The payload length depends on the opcode. The two write opcodes that carry an explicit count use that count. The set-class and masked-write opcodes use the number of set bits in their mask field. A gather always has one payload word. Every other opcode has none. A marker on the input flags the last word of a stream. If the stream ends before the current command's payload is complete, the block raises a truncation flag and returns to header decoding. The block only parses the stream: it does not execute commands, write registers, fetch buffers or arbitrate locks.

Top module: `cmd_stream_decoder`

## Requirements
- R1: Every word accepted with `inValid` high produces exactly one result, with `outValid` high on the following cycle. In the result, `outOpcode` is bits 31:28 of a header word. Header fields that the opcode does not define are zero. All header fields are zero on payload results.
- R2: Set-class (opcode 0): `outMask` is bits 5:0, `outClass` is bits 15:6 and `outOffset` is bits 27:16. `outPayloadLen` is the number of set bits in the 6-bit mask, and a zero mask gives no payload.
- R3: Incrementing write (opcode 1) and non-incrementing write (opcode 2): `outOffset` is bits 27:16. `outCount` and `outPayloadLen` both equal bits 15:0.
- R4: Masked write (opcode 3): `outOffset` is bits 27:16 and `outMask` is bits 15:0. `outPayloadLen` is the number of set bits in that 16-bit mask.
- R5: Immediate (opcode 4): `outOffset` is bits 27:16, `outImmData` is bits 15:0, and there is no payload.
- R6: Restart (opcode 5): `outRestartAddr` is bits 27:0 shifted left by four, with zeros in the low bits, and there is no payload.
- R7: Gather (opcode 6): `outOffset` is bits 27:16, `outInsert` is bit 15, `outType` is bit 14 and `outCount` is bits 13:0. `outPayloadLen` is 1.
- R8: Extended (opcode 14): the sub-opcode in bits 27:24 sets `outExtKind`. Sub-op 0 gives 1 (acquire) and sub-op 1 gives 2 (release), each with `outLockIdx` taken from bits 7:0. Any other sub-op gives 3 (unknown) with a zero lock index. There is no payload.
- R9: Opcodes 7 to 13 and 15 are reported as headers with zero payload and all other fields zero.
- R10: After a header with a non-zero payload length N, the next N accepted words are reported with `outIsHeader` low. Only the N-th of them has `outLastPayload` high, and the word after it is decoded as a header. A header result never has `outLastPayload` high.
- R11: A word accepted with `inLast` high sets `outTruncated` in its result if the command is still incomplete after that word. The word after it is always decoded as a header.
- R12: A synchronous reset, and any cycle with `inValid` low, produce no result on the next cycle. The reset also makes the first word after it a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input word is present this cycle |
| inWord | input | 32 | Command word |
| inLast | input | 1 | Marks the final word of a stream |
| outValid | output | 1 | A result is present |
| outIsHeader | output | 1 | The result is for a header word |
| outLastPayload | output | 1 | The result is for the final payload word of a command |
| outTruncated | output | 1 | The stream ended before the command was complete |
| outOpcode | output | 4 | Header opcode |
| outOffset | output | 12 | Register offset |
| outClass | output | 10 | Class identifier (set-class) |
| outMask | output | 16 | Mask field |
| outCount | output | 16 | Count field |
| outImmData | output | 16 | Immediate data |
| outLockIdx | output | 8 | Lock index |
| outExtKind | output | 2 | 0 none, 1 acquire, 2 release, 3 unknown |
| outInsert | output | 1 | Gather insert flag |
| outType | output | 1 | Gather type flag |
| outRestartAddr | output | 32 | Restart target address |
| outPayloadLen | output | CNT_W | Number of payload words following the header |

## Verification
The assertions check, on every result, that the reported payload length agrees with the header's own fields: the population count of the mask for set-class and masked writes, the count field for the two write opcodes, one for a gather and zero for immediate, restart and extended commands. They also check that results appear only after accepted words, that a header never carries the last-payload flag, and that truncation appears only on end-of-stream words. Whether payload words are counted off correctly across many headers, whether a header follows the final payload word, and how mid-command end markers and resets recover the stream can only be seen by running word sequences through the bench's reference model.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;

  localparam int WORD_W = 32;

  localparam logic [3:0] OP_SETCLASS = 4'd0;
  localparam logic [3:0] OP_INCR     = 4'd1;
  localparam logic [3:0] OP_NONINCR  = 4'd2;
  localparam logic [3:0] OP_MASKED   = 4'd3;
  localparam logic [3:0] OP_IMM      = 4'd4;
  localparam logic [3:0] OP_RESTART  = 4'd5;
  localparam logic [3:0] OP_GATHER   = 4'd6;
  localparam logic [3:0] OP_EXTEND   = 4'd14;

  localparam logic [3:0] SUB_ACQUIRE = 4'd0;
  localparam logic [3:0] SUB_RELEASE = 4'd1;

  localparam logic [1:0] EXT_NONE    = 2'd0;
  localparam logic [1:0] EXT_ACQUIRE = 2'd1;
  localparam logic [1:0] EXT_RELEASE = 2'd2;
  localparam logic [1:0] EXT_UNKNOWN = 2'd3;

  // Strobes from control to datapath for one accepted word.
  typedef struct packed {
    logic take;
    logic isHdr;
    logic isLastPay;
    logic trunc;
  } ctrlStrobes_t;

  // Decoded header fields.
  typedef struct packed {
    logic [3:0]  opcode;
    logic [11:0] offset;
    logic [9:0]  classId;
    logic [15:0] mask;
    logic [15:0] count;
    logic [15:0] immData;
    logic [7:0]  lockIdx;
    logic [1:0]  extKind;
    logic        insert;
    logic        gType;
    logic [31:0] restartAddr;
  } hdrFields_t;

endpackage

// File: rtl/cmd_dec_popcount.sv
module cmd_dec_popcount #(
  parameter int W = 16,
  localparam int OUT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     bits,
  output logic [OUT_W-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + OUT_W'(bits[i]);
    end
  end
endmodule

// File: rtl/cmd_dec_ctrl.sv
module cmd_dec_ctrl
  import cmd_dec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inLast,
  input  logic [CNT_W-1:0] hdrLen,
  output ctrlStrobes_t     strb
);
  logic [CNT_W-1:0] remaining;
  logic             atHeader;
  logic             atFinal;

  assign atHeader = (remaining == '0);
  assign atFinal  = (remaining == CNT_W'(1));

  always_comb begin
    strb.take      = inValid;
    strb.isHdr     = atHeader;
    strb.isLastPay = !atHeader && atFinal;
    if (atHeader) begin
      strb.trunc = inValid && inLast && (hdrLen != '0);
    end else begin
      strb.trunc = inValid && inLast && !atFinal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else if (inValid) begin
      if (inLast) begin
        remaining <= '0;
      end else if (atHeader) begin
        remaining <= hdrLen;
      end else begin
        remaining <= remaining - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cmd_dec_datapath.sv
module cmd_dec_datapath
  import cmd_dec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WORD_W-1:0]  inWord,
  input  ctrlStrobes_t       strb,
  output logic [CNT_W-1:0]   hdrLen,
  output logic               outValid,
  output logic               outIsHeader,
  output logic               outLastPayload,
  output logic               outTruncated,
  output hdrFields_t         outFields,
  output logic [CNT_W-1:0]   outPayloadLen
);
  localparam int SC_MASK_W = 6;
  localparam int MW_MASK_W = 16;
  localparam int SC_PC_W   = $clog2(SC_MASK_W + 1);
  localparam int MW_PC_W   = $clog2(MW_MASK_W + 1);

  logic [3:0]         op;
  logic [SC_PC_W-1:0] scOnes;
  logic [MW_PC_W-1:0] mwOnes;
  hdrFields_t         dec;

  assign op = inWord[31:28];

  cmd_dec_popcount #(.W(SC_MASK_W)) uScPop (
    .bits (inWord[SC_MASK_W-1:0]),
    .ones (scOnes)
  );

  cmd_dec_popcount #(.W(MW_MASK_W)) uMwPop (
    .bits (inWord[MW_MASK_W-1:0]),
    .ones (mwOnes)
  );

  // Payload length per opcode.
  always_comb begin
    unique case (op)
      OP_SETCLASS:         hdrLen = CNT_W'(scOnes);
      OP_INCR, OP_NONINCR: hdrLen = CNT_W'(inWord[15:0]);
      OP_MASKED:           hdrLen = CNT_W'(mwOnes);
      OP_GATHER:           hdrLen = CNT_W'(1);
      default:             hdrLen = '0;
    endcase
  end

  // Field extraction per opcode.
  always_comb begin
    dec        = '0;
    dec.opcode = op;
    unique case (op)
      OP_SETCLASS: begin
        dec.offset  = inWord[27:16];
        dec.classId = inWord[15:6];
        dec.mask    = {10'd0, inWord[5:0]};
      end
      OP_INCR, OP_NONINCR: begin
        dec.offset = inWord[27:16];
        dec.count  = inWord[15:0];
      end
      OP_MASKED: begin
        dec.offset = inWord[27:16];
        dec.mask   = inWord[15:0];
      end
      OP_IMM: begin
        dec.offset  = inWord[27:16];
        dec.immData = inWord[15:0];
      end
      OP_RESTART: begin
        dec.restartAddr = {inWord[27:0], 4'd0};
      end
      OP_GATHER: begin
        dec.offset = inWord[27:16];
        dec.insert = inWord[15];
        dec.gType  = inWord[14];
        dec.count  = {2'd0, inWord[13:0]};
      end
      OP_EXTEND: begin
        if (inWord[27:24] == SUB_ACQUIRE) begin
          dec.extKind = EXT_ACQUIRE;
          dec.lockIdx = inWord[7:0];
        end else if (inWord[27:24] == SUB_RELEASE) begin
          dec.extKind = EXT_RELEASE;
          dec.lockIdx = inWord[7:0];
        end else begin
          dec.extKind = EXT_UNKNOWN;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid       <= 1'b0;
      outIsHeader    <= 1'b0;
      outLastPayload <= 1'b0;
      outTruncated   <= 1'b0;
      outFields      <= '0;
      outPayloadLen  <= '0;
    end else begin
      outValid <= strb.take;
      if (strb.take) begin
        outIsHeader    <= strb.isHdr;
        outLastPayload <= strb.isLastPay;
        outTruncated   <= strb.trunc;
        outFields      <= strb.isHdr ? dec : '0;
        outPayloadLen  <= strb.isHdr ? hdrLen : '0;
      end
    end
  end
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import cmd_dec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [31:0]      inWord,
  input  logic             inLast,
  output logic             outValid,
  output logic             outIsHeader,
  output logic             outLastPayload,
  output logic             outTruncated,
  output logic [3:0]       outOpcode,
  output logic [11:0]      outOffset,
  output logic [9:0]       outClass,
  output logic [15:0]      outMask,
  output logic [15:0]      outCount,
  output logic [15:0]      outImmData,
  output logic [7:0]       outLockIdx,
  output logic [1:0]       outExtKind,
  output logic             outInsert,
  output logic             outType,
  output logic [31:0]      outRestartAddr,
  output logic [CNT_W-1:0] outPayloadLen
);
  ctrlStrobes_t     strb;
  logic [CNT_W-1:0] hdrLen;
  hdrFields_t       fields;

  cmd_dec_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inLast  (inLast),
    .hdrLen  (hdrLen),
    .strb    (strb)
  );

  cmd_dec_datapath #(.CNT_W(CNT_W)) uData (
    .clk            (clk),
    .rst            (rst),
    .inWord         (inWord),
    .strb           (strb),
    .hdrLen         (hdrLen),
    .outValid       (outValid),
    .outIsHeader    (outIsHeader),
    .outLastPayload (outLastPayload),
    .outTruncated   (outTruncated),
    .outFields      (fields),
    .outPayloadLen  (outPayloadLen)
  );

  assign outOpcode      = fields.opcode;
  assign outOffset      = fields.offset;
  assign outClass       = fields.classId;
  assign outMask        = fields.mask;
  assign outCount       = fields.count;
  assign outImmData     = fields.immData;
  assign outLockIdx     = fields.lockIdx;
  assign outExtKind     = fields.extKind;
  assign outInsert      = fields.insert;
  assign outType        = fields.gType;
  assign outRestartAddr = fields.restartAddr;
endmodule

// File: rtl/cmd_dec_checker.sv
module cmd_dec_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inLast,
  input logic             outValid,
  input logic             outIsHeader,
  input logic             outLastPayload,
  input logic             outTruncated,
  input logic [3:0]       outOpcode,
  input logic [15:0]      outMask,
  input logic [15:0]      outCount,
  input logic [CNT_W-1:0] outPayloadLen
);
  logic hdrOut;
  assign hdrOut = outValid && outIsHeader;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid); // R12

  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R12

  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid)); // R1

  AST_SETCL_LEN: assert property (@(posedge clk) disable iff (rst)
    (hdrOut && outOpcode == 4'd0) |->
      outPayloadLen == CNT_W'($countones(outMask[5:0]))); // R2

  AST_WRITE_LEN: assert property (@(posedge clk) disable iff (rst)
    (hdrOut && (outOpcode == 4'd1 || outOpcode == 4'd2)) |->
      outPayloadLen == CNT_W'(outCount)); // R3

  AST_MASK_LEN: assert property (@(posedge clk) disable iff (rst)
    (hdrOut && outOpcode == 4'd3) |->
      outPayloadLen == CNT_W'($countones(outMask))); // R4

  AST_IMM_LEN: assert property (@(posedge clk) disable iff (rst)
    (hdrOut && outOpcode == 4'd4) |-> outPayloadLen == '0); // R5

  AST_RESTART_LEN: assert property (@(posedge clk) disable iff (rst)
    (hdrOut && outOpcode == 4'd5) |-> outPayloadLen == '0); // R6

  AST_GATHER_LEN: assert property (@(posedge clk) disable iff (rst)
    (hdrOut && outOpcode == 4'd6) |-> outPayloadLen == CNT_W'(1)); // R7

  AST_EXT_LEN: assert property (@(posedge clk) disable iff (rst)
    (hdrOut && outOpcode == 4'd14) |-> outPayloadLen == '0); // R8

  AST_HDR_NOT_LAST: assert property (@(posedge clk) disable iff (rst)
    hdrOut |-> !outLastPayload); // R10

  AST_TRUNC_ON_END: assert property (@(posedge clk) disable iff (rst)
    (outValid && outTruncated) |-> $past(inLast)); // R11
endmodule

bind cmd_stream_decoder cmd_dec_checker #(.CNT_W(CNT_W)) uChecker (
  .clk            (clk),
  .rst            (rst),
  .inValid        (inValid),
  .inLast         (inLast),
  .outValid       (outValid),
  .outIsHeader    (outIsHeader),
  .outLastPayload (outLastPayload),
  .outTruncated   (outTruncated),
  .outOpcode      (outOpcode),
  .outMask        (outMask),
  .outCount       (outCount),
  .outPayloadLen  (outPayloadLen)
);

// File: tb/cmd_stream_decoder_test.sv
`timescale 1ns/1ps
module cmd_stream_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        inLast = 1'b0;

  logic        outValid, outIsHeader, outLastPayload, outTruncated;
  logic [3:0]  outOpcode;
  logic [11:0] outOffset;
  logic [9:0]  outClass;
  logic [15:0] outMask, outCount, outImmData, outPayloadLen;
  logic [7:0]  outLockIdx;
  logic [1:0]  outExtKind;
  logic        outInsert, outType;
  logic [31:0] outRestartAddr;

  cmd_stream_decoder #(.CNT_W(16)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord), .inLast(inLast),
    .outValid(outValid), .outIsHeader(outIsHeader),
    .outLastPayload(outLastPayload), .outTruncated(outTruncated),
    .outOpcode(outOpcode), .outOffset(outOffset), .outClass(outClass),
    .outMask(outMask), .outCount(outCount), .outImmData(outImmData),
    .outLockIdx(outLockIdx), .outExtKind(outExtKind), .outInsert(outInsert),
    .outType(outType), .outRestartAddr(outRestartAddr),
    .outPayloadLen(outPayloadLen)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference model state and expectations.
  int remain = 0;
  bit eV, eH, eL, eT;
  int eOp, eOff, eCls, eMask, eCnt, eImm, eLock, eKind, eIns, eTyp, eLen;
  logic [31:0] eRst;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string tagFor(int op);
    case (op)
      0: return "R2";
      1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      14: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic int ones(int v, int nbits);
    int n = 0;
    for (int i = 0; i < nbits; i++) if ((v >> i) & 1) n++;
    return n;
  endfunction

  task automatic compareNow();
    string t;
    check(eV ? "R1" : "R12", "outValid", outValid, eV);
    if (eV) begin
      check("R10", "outIsHeader", outIsHeader, eH);
      check("R10", "outLastPayload", outLastPayload, eL);
      check("R11", "outTruncated", outTruncated, eT);
      t = eH ? tagFor(eOp) : "R1";
      check(t, "opcode", outOpcode, eOp);
      check(t, "offset", outOffset, eOff);
      check(t, "class", outClass, eCls);
      check(t, "mask", outMask, eMask);
      check(t, "count", outCount, eCnt);
      check(t, "imm", outImmData, eImm);
      check(t, "lock", outLockIdx, eLock);
      check(t, "extKind", outExtKind, eKind);
      check(t, "insert", outInsert, eIns);
      check(t, "type", outType, eTyp);
      check(t, "restart", outRestartAddr, eRst);
      check(t, "payloadLen", outPayloadLen, eLen);
    end
  endtask

  task automatic modelWord(bit r, bit v, logic [31:0] w, bit last);
    int op, lo;
    eOp = 0; eOff = 0; eCls = 0; eMask = 0; eCnt = 0; eImm = 0;
    eLock = 0; eKind = 0; eIns = 0; eTyp = 0; eLen = 0; eRst = '0;
    eH = 0; eL = 0; eT = 0;
    if (r) begin
      eV = 0; remain = 0;
    end else if (!v) begin
      eV = 0;
    end else begin
      eV = 1;
      if (remain == 0) begin
        eH = 1;
        op = int'(w[31:28]);
        lo = int'(w[15:0]);
        eOp = op;
        if (op == 0) begin
          eOff = int'(w[27:16]); eCls = int'(w[15:6]); eMask = int'(w[5:0]);
          eLen = ones(eMask, 6);
        end else if (op == 1 || op == 2) begin
          eOff = int'(w[27:16]); eCnt = lo; eLen = lo;
        end else if (op == 3) begin
          eOff = int'(w[27:16]); eMask = lo; eLen = ones(lo, 16);
        end else if (op == 4) begin
          eOff = int'(w[27:16]); eImm = lo;
        end else if (op == 5) begin
          eRst = w << 4;
        end else if (op == 6) begin
          eOff = int'(w[27:16]); eIns = int'(w[15]); eTyp = int'(w[14]);
          eCnt = lo % 16384; eLen = 1;
        end else if (op == 14) begin
          if (w[27:24] == 0) begin eKind = 1; eLock = int'(w[7:0]); end
          else if (w[27:24] == 1) begin eKind = 2; eLock = int'(w[7:0]); end
          else eKind = 3;
        end
        eT = last && (eLen != 0);
        remain = last ? 0 : eLen;
      end else begin
        eL = (remain == 1);
        eT = last && (remain != 1);
        remain = last ? 0 : remain - 1;
      end
    end
  endtask

  // One cycle: check the previous cycle's result, then drive new inputs.
  task automatic step(bit r, bit v, logic [31:0] w, bit last);
    @(negedge clk);
    compareNow();
    rst = r; inValid = v; inWord = w; inLast = last;
    modelWord(r, v, w, last);
  endtask

  task automatic send(logic [31:0] w, bit last = 0);
    step(0, 1, w, last);
  endtask

  task automatic idle();
    step(0, 0, '0, 0);
  endtask

  initial begin
    eV = 0;
    step(1, 0, '0, 0);
    step(1, 0, '0, 0);
    idle(); // reset state observed here (R12)
    // R2: set-class with mask 0x2B (4 payload), then zero mask
    send(32'h0123_4AEB);
    for (int i = 0; i < 4; i++) send(32'hA000_0000 + i);
    send(32'h0ABC_0FC0);
    // R3: incrementing count 3, non-incrementing count 2, count 0
    send(32'h1456_0003); send(32'h1111_1111); idle(); send(32'h2222_2222); send(32'h3333_3333);
    send(32'h2789_0002); send(32'hFFFF_FFFF); send(32'h0000_0000);
    send(32'h1FFF_0000);
    // R4: masked write 0x8001
    send(32'h3321_8001); send(32'h5555_5555); send(32'h6666_6666);
    // R5, R6, R7
    send(32'h4ABC_BEEF);
    send(32'h5FED_CBA9);
    send(32'h6123_C123); send(32'h8000_1000);
    send(32'h6FFF_3FFF); send(32'h0000_0040);
    // R8: acquire, release, unknown
    send(32'hE0FF_FF5A); send(32'hE1AA_AA3C); send(32'hE7AA_AA3C);
    // R9: unlisted opcodes
    send(32'h7FFF_FFFF); send(32'hFFFF_0003); send(32'hB123_4567);
    // R11: end mid-payload, end on header with payload, clean ends
    send(32'h1000_0005); send(32'h1); send(32'h2, 1);
    send(32'h1000_0002, 1);
    send(32'h4000_0001, 1);
    send(32'h6000_0000); send(32'h1234, 1);
    send(32'h4000_0002);
    // R12: reset mid-command, next word is a header
    send(32'h1000_0004); send(32'h9); step(1, 0, '0, 0);
    send(32'h4000_0077);
    // Mixed random stream
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] w;
      int pick;
      w = $urandom;
      pick = $urandom % 10;
      if (pick < 3) w[15:0] = 16'($urandom % 6);
      if ($urandom % 5 == 0) idle();
      else send(w, ($urandom % 20) == 0);
    end
    idle(); idle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule